// File: doc/BRIEF.md
# Shared-Prefix Multi-Pattern Byte Stream Matcher

This block scans a byte stream, one byte per accepted cycle, for a fixed set of case-insensitive text patterns built in at elaboration time. Every incoming byte is compared exactly once, at the input, and turned into a one-hot vector over a reduced character set. Those single-bit lines then travel down a short chain of plain flip-flop stages. Each pattern is detected by an AND of one selected bit from each stage. Nothing else in the datapath compares bytes.

Patterns longer than eight characters are split into three parts: a four-character lead group, a second four-character group, and a short tail. Lead-group detectors are shared by every pattern that starts the same way. Second-group detectors are shared only among patterns under the same lead group. Each detector's result is registered and shifted along a per-pattern alignment chain, so that it meets the tail comparison on the cycle the last tail byte arrives. Patterns of up to eight characters are matched directly from the stage chain. The per-pattern flags are reduced in groups of eight and then ORed into a single hit pulse.

Top module: `pfx_matcher`

## Requirements
- R1: The decoder maps each byte onto 40 lines: letters on lines 0-25 (a..z), digits on lines 26-35, and `/`, `-`, `.`, `_` on lines 36-39. A byte in this set raises exactly one line. Any other byte raises none, so no pattern can match across it, and `_` never stands in for `.`.
- R2: An upper-case letter and its lower-case form raise the same line, so every pattern matches in any mix of cases.
- R3: A cycle with `inValid` low does not advance the stage chain or the alignment chains and produces no hit. Idle cycles may therefore be placed between the bytes of a pattern without breaking the match.
- R4: When the byte that completes a pattern is presented with `inValid` high in cycle c, `hit` is high in cycle c+2 for exactly that one cycle.
- R5: The short patterns `admin` (hitVec bit 4) and `root.exe` (hitVec bit 5) are detected as whole strings from the stage chain.
- R6: The long patterns `/cgi-bin/ph` (bit 0), `/cgi-bin/te` (bit 1), `/cgi-win/x` (bit 2) and `/scripts/a` (bit 3) are detected only when all their bytes arrive as consecutive accepted bytes. A partial pattern produces no hit.
- R7: A second-level group counts only when it directly follows its own lead group (`-bin` and `-win` after `/cgi`, `ipts` after `/scr`). Mixing the groups of different patterns gives no hit.
- R8: Overlapping, repeated or falsely-started occurrences are each reported independently, one pulse per completing byte.
- R9: `hitVec` carries the per-pattern flags with the bit positions given in R5 and R6. `hit` is high exactly when any bit of `hitVec` is high.
- R10: A synchronous reset clears every stage, every alignment chain and both outputs. Bytes accepted before the reset cannot complete a pattern after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | The byte on inByte is accepted this cycle |
| inByte | input | 8 | Stream byte |
| hit | output | 1 | Some pattern completed two cycles earlier |
| hitVec | output | 6 | Per-pattern completion flags, aligned with hit |

## Verification
The hardest situation to reach is a long pattern whose two prefix groups and tail must line up through separate registered chains. The case where this goes wrong is when those chains drift apart from the byte stage chain, which happens when accepted bytes are interleaved with idle cycles or cut by a reset. The stimulus therefore splits a long pattern with idle cycles in the middle of its second group, and resets the block one byte before a pattern would finish. It also builds strings that combine a lead group with the wrong second group, which shows that each shared detector is tied to its own parent.

// File: rtl/pfx_match_pkg.sv
`timescale 1ns/1ps
package pfx_match_pkg;

  localparam int ALPHA_LINES = 40;
  localparam int PFX_LEN     = 4;
  localparam int GRP_SIZE    = 8;
  localparam int NUM_FIRST   = 2;
  localparam int NUM_SECOND  = 3;
  localparam int NUM_PAT     = 6;

  // Strings are right-justified: the last character sits in bits [7:0],
  // so the character d positions before the end lines up with stage d.
  localparam logic [31:0] FIRST_STR  [NUM_FIRST]  = '{"/cgi", "/scr"};
  localparam logic [31:0] SECOND_STR [NUM_SECOND] = '{"-bin", "-win", "ipts"};
  localparam int          SECOND_PARENT [NUM_SECOND] = '{0, 0, 1};

  localparam bit          PAT_SPLIT  [NUM_PAT] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam int          PAT_SECOND [NUM_PAT] = '{0, 0, 1, 2, 0, 0};
  localparam logic [63:0] PAT_TAIL   [NUM_PAT] = '{
    {40'h0, "/ph"}, {40'h0, "/te"}, {48'h0, "/x"}, {48'h0, "/a"},
    {24'h0, "admin"}, "root.exe"};
  localparam int          PAT_TLEN   [NUM_PAT] = '{3, 3, 2, 2, 5, 8};

  typedef struct packed {
    logic shift;  // accept a byte into the chains this cycle
    logic fresh;  // stage 0 holds a byte accepted on the previous edge
  } strb_t;

  function automatic logic [7:0] lineChar(int k);
    if (k < 26) return 8'(97 + k);
    if (k < 36) return 8'(48 + k - 26);
    case (k)
      36:      return 8'h2f;
      37:      return 8'h2d;
      38:      return 8'h2e;
      default: return 8'h5f;
    endcase
  endfunction

  function automatic int lineOf(logic [7:0] c);
    for (int k = 0; k < ALPHA_LINES; k++) begin
      if (c == lineChar(k)) return k;
      if (k < 26 && c == lineChar(k) - 8'h20) return k;
    end
    return -1;
  endfunction

  function automatic int tapDepth();
    int m = PFX_LEN;
    for (int p = 0; p < NUM_PAT; p++)
      if (PAT_TLEN[p] > m) m = PAT_TLEN[p];
    return m;
  endfunction

endpackage

// File: rtl/pfxm_decoder.sv
`timescale 1ns/1ps
module pfxm_decoder
  import pfx_match_pkg::*;
(
  input  logic [7:0]             inByte,
  output logic [ALPHA_LINES-1:0] decLine
);

  for (genvar k = 0; k < ALPHA_LINES; k++) begin : g_line
    localparam logic [7:0] LOW_CODE  = lineChar(k);
    localparam logic [7:0] HIGH_CODE = LOW_CODE - 8'h20;
    localparam bit         IS_ALPHA  = (k < 26);
    assign decLine[k] = (inByte == LOW_CODE) || (IS_ALPHA && (inByte == HIGH_CODE));
  end

  always_comb begin
    AST_ONE_LINE_PER_BYTE: assert ($onehot0(decLine)); // R1
  end

endmodule

// File: rtl/pfxm_ctrl.sv
`timescale 1ns/1ps
module pfxm_ctrl
  import pfx_match_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  inValid,
  output strb_t strb
);

  logic freshQ;

  always_ff @(posedge clk) begin
    if (rst) freshQ <= 1'b0;
    else     freshQ <= inValid;
  end

  assign strb.shift = inValid && !rst;
  assign strb.fresh = freshQ;

endmodule

// File: rtl/pfxm_datapath.sv
`timescale 1ns/1ps
module pfxm_datapath
  import pfx_match_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  strb_t                  strb,
  input  logic [ALPHA_LINES-1:0] decLine,
  output logic                   hitQ,
  output logic [NUM_PAT-1:0]     hitVecQ
);

  localparam int DEPTH   = tapDepth();
  localparam int NGRP    = (NUM_PAT + GRP_SIZE - 1) / GRP_SIZE;
  localparam int PAD_LEN = NGRP * GRP_SIZE;

  // decoded character stages; taps[d] holds the byte accepted d bytes ago
  logic [ALPHA_LINES-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < DEPTH; d++) taps[d] <= '0;
    end else if (strb.shift) begin
      taps[0] <= decLine;
      for (int d = 1; d < DEPTH; d++) taps[d] <= taps[d-1];
    end
  end

  // lead-group detectors, each with an aging chain of PFX_LEN bytes
  logic [NUM_FIRST-1:0] firstOld;

  for (genvar i = 0; i < NUM_FIRST; i++) begin : g_first
    logic [PFX_LEN-1:0] term;
    logic               firstNow;
    logic [PFX_LEN-1:0] aged;
    for (genvar d = 0; d < PFX_LEN; d++) begin : g_pos
      localparam int LN = lineOf(FIRST_STR[i][8*d +: 8]);
      assign term[d] = taps[d][LN];
    end
    assign firstNow = &term;
    always_ff @(posedge clk) begin
      if (rst)             aged <= '0;
      else if (strb.shift) aged <= {aged[PFX_LEN-2:0], firstNow};
    end
    assign firstOld[i] = aged[PFX_LEN-1];
  end

  // second-level detectors, each gated by its own lead group
  logic [NUM_SECOND-1:0] secondNow;

  for (genvar j = 0; j < NUM_SECOND; j++) begin : g_second
    logic [PFX_LEN-1:0] term;
    for (genvar d = 0; d < PFX_LEN; d++) begin : g_pos
      localparam int LN = lineOf(SECOND_STR[j][8*d +: 8]);
      assign term[d] = taps[d][LN];
    end
    assign secondNow[j] = firstOld[SECOND_PARENT[j]] && (&term);
  end

  // per-pattern match terms
  logic [NUM_PAT-1:0] matchNow;

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    localparam int S = PAT_TLEN[p];
    logic [S-1:0] term;
    for (genvar d = 0; d < S; d++) begin : g_pos
      localparam int LN = lineOf(PAT_TAIL[p][8*d +: 8]);
      assign term[d] = taps[d][LN];
    end
    if (PAT_SPLIT[p]) begin : g_split
      logic [S-1:0] lag;
      if (S == 1) begin : g_one
        always_ff @(posedge clk) begin
          if (rst)             lag <= '0;
          else if (strb.shift) lag <= secondNow[PAT_SECOND[p]];
        end
      end else begin : g_many
        always_ff @(posedge clk) begin
          if (rst)             lag <= '0;
          else if (strb.shift) lag <= {lag[S-2:0], secondNow[PAT_SECOND[p]]};
        end
      end
      assign matchNow[p] = lag[S-1] && (&term);
    end else begin : g_whole
      assign matchNow[p] = &term;
    end
  end

  // OR reduction in groups of eight
  logic [PAD_LEN-1:0] padded;
  logic [NGRP-1:0]    grpAny;

  always_comb begin
    padded = '0;
    padded[NUM_PAT-1:0] = matchNow;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grpAny[g] = |padded[g*GRP_SIZE +: GRP_SIZE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hitQ    <= 1'b0;
      hitVecQ <= '0;
    end else begin
      hitQ    <= strb.fresh && (|grpAny);
      hitVecQ <= strb.fresh ? matchNow : '0;
    end
  end

  AST_IDLE_HOLDS_TAPS: assert property (@(posedge clk) disable iff (rst)
    !strb.shift |=> ($stable(taps[0]) && $stable(taps[DEPTH-1]))); // R3
  AST_TAPS_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    strb.shift |=> (taps[1] == $past(taps[0]))); // R3
  AST_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hitQ && hitVecQ == '0)); // R10
  AST_FLAG_IMPLIES_HIT: assert property (@(posedge clk) disable iff (rst)
    (hitVecQ != '0) |-> hitQ); // R9

endmodule

// File: rtl/pfx_matcher.sv
`timescale 1ns/1ps
module pfx_matcher
  import pfx_match_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [7:0]         inByte,
  output logic               hit,
  output logic [NUM_PAT-1:0] hitVec
);

  strb_t                  strb;
  logic [ALPHA_LINES-1:0] decLine;

  pfxm_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strb    (strb)
  );

  pfxm_decoder u_dec (
    .inByte  (inByte),
    .decLine (decLine)
  );

  pfxm_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .decLine (decLine),
    .hitQ    (hit),
    .hitVecQ (hitVec)
  );

  AST_HIT_TWO_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(inValid, 2)); // R4

endmodule

// File: tb/pfx_matcher_tb_top.sv
`timescale 1ns/1ps
module pfx_matcher_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       hit;
  logic [5:0] hitVec;

  int total = 0;
  int bad = 0;
  int hitCnt = 0;
  logic [5:0] seenVec = '0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pfx_matcher dut_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inByte  (inByte),
    .hit     (hit),
    .hitVec  (hitVec)
  );

  localparam int NV = 16;
  localparam string STIM [NV] = '{
    "/cgi-bin/ph", "/cgi-bin/te", "/cgi-win/x", "/scripts/a",
    "admin", "root.exe", "/scr-bin/ph", "/cgiipts/a",
    "/cgi-win/ph", "xx/CGI-BIN/Te", "adminadmin", "adm#in",
    "/cgi/cgi-bin/ph", "/cgi-bin/p", "RoOt_exe", "root.exeadmin"};
  localparam logic [5:0] MASK [NV] = '{
    6'b000001, 6'b000010, 6'b000100, 6'b001000,
    6'b010000, 6'b100000, 6'b000000, 6'b000000,
    6'b000000, 6'b000010, 6'b010000, 6'b000000,
    6'b000001, 6'b000000, 6'b000000, 6'b110000};
  localparam int CNT [NV] = '{1, 1, 1, 1, 1, 1, 0, 0, 0, 1, 2, 0, 1, 0, 0, 2};
  localparam string REQ [NV] = '{
    "R6", "R6", "R6", "R6", "R5", "R5", "R7", "R7",
    "R7", "R2", "R8", "R1", "R8", "R6", "R1", "R9"};

  always @(negedge clk) begin
    if (!rst && hit) begin
      hitCnt  <= hitCnt + 1;
      seenVec <= seenVec | hitVec;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inByte = b;
  endtask

  task automatic sendStr(string s);
    for (int k = 0; k < s.len(); k++) sendByte(s[k]);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic clearSeen();
    @(negedge clk);
    hitCnt = 0;
    seenVec = '0;
  endtask

  initial begin
    // reset state (R10)
    doReset();
    @(negedge clk);
    check(hit == 1'b0, "R10", "hit after reset", int'(hit), 0);
    check(hitVec == 6'b0, "R10", "hitVec after reset", int'(hitVec), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      doReset();
      clearSeen();
      sendStr(STIM[v]);
      idle(4);
      check(hitCnt == CNT[v], REQ[v], $sformatf("vec%0d pulse count", v), hitCnt, CNT[v]);
      check(seenVec == MASK[v], REQ[v], $sformatf("vec%0d flags", v), int'(seenVec), int'(MASK[v]));
    end

    // latency: completing byte in cycle c, hit in c+2 only (R4)
    doReset();
    clearSeen();
    sendStr("admi");
    sendByte("n");
    @(negedge clk);
    inValid = 1'b0;
    check(hit == 1'b0, "R4", "hit at c+1", int'(hit), 0);
    @(negedge clk);
    check(hit == 1'b1, "R4", "hit at c+2", int'(hit), 1);
    check(hitVec == 6'b010000, "R9", "hitVec at c+2", int'(hitVec), 16);
    @(negedge clk);
    check(hit == 1'b0, "R4", "hit at c+3", int'(hit), 0);

    // idle cycles inside a long pattern (R3)
    doReset();
    clearSeen();
    sendStr("/cgi-b");
    idle(3);
    check(hitCnt == 0 && hit == 1'b0, "R3", "no hit during idle", hitCnt, 0);
    sendStr("in/ph");
    idle(4);
    check(hitCnt == 1, "R3", "split stream pulse count", hitCnt, 1);
    check(seenVec == 6'b000001, "R3", "split stream flags", int'(seenVec), 1);

    // reset one byte before completion (R10)
    doReset();
    clearSeen();
    sendStr("/cgi-bin/p");
    doReset();
    sendByte("h");
    idle(4);
    check(hitCnt == 0, "R10", "long pattern across reset", hitCnt, 0);
    doReset();
    clearSeen();
    sendStr("admi");
    doReset();
    sendByte("n");
    idle(4);
    check(hitCnt == 0, "R10", "short pattern across reset", hitCnt, 0);

    // back-to-back long patterns sharing both groups (R8)
    doReset();
    clearSeen();
    sendStr("/cgi-bin/te/cgi-bin/ph");
    idle(4);
    check(hitCnt == 2, "R8", "back-to-back pulse count", hitCnt, 2);
    check(seenVec == 6'b000011, "R8", "back-to-back flags", int'(seenVec), 3);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule